// File: doc/BRIEF.md
# Audio Playback Sample Queue with DMA Request

This block sits between a memory-mapped register port and the sample input of an audio DAC. Software or a DMA engine writes sample containers, 16-bit or 32-bit, into a write-only data register. Each written container is converted into one 24-bit DAC word and queued in a 64-entry store. On every pulse of the external sample-rate strobe the block hands the DAC one output pair. In stereo mode that pair is two queued entries, left then right. In mono mode it is one entry copied to both sides. When the queue holds too few entries at a strobe, the block either outputs silence or repeats the previous pair, as software chooses.

A DMA request line with hysteresis asks for more data. The request rises when free space reaches a programmable trigger level. Once raised, it stays high until free space drops below a separately coded clear level. Every clear level is at least 4, so a raised request always leaves room for a 4-word burst. A control register holds all modes and a 3-bit sample-rate code for the DAC. A status register reports free space and two sticky error flags, each cleared by writing 1.

Top module: `audio_tx_fifo`

## Requirements
- R1: The control register is at byte offset 0x04 and the status register at 0x08; reads of any other offset return 0. Control reads back only its defined fields (mask 0xE5603F70), and bit 0 always reads 0. Status bits [6:0] hold free space, bit 8 the underrun flag and bit 9 the overflow flag. After reset, control is 0 and status is 0x40.
- R2: With control bit 5 = 0, a write to offset 0x0C takes bits [15:0] as sample s. Control bit 24 = 0 stores {s, 8'h00}. Control bit 24 = 1 stores {s, s[15:8]}.
- R3: With control bit 5 = 1, a data write stores bits [31:8] of the container and ignores bits [7:0], whatever control bit 24 holds.
- R4: In stereo (control bit 6 = 0), a strobe with at least two entries queued pops the oldest entry to dac_left and the next to dac_right. In mono (bit 6 = 1), a strobe with at least one entry pops one entry to both outputs.
- R5: A strobe that finds fewer entries than it needs pops nothing and sets the underrun flag. If control bit 26 = 0 both outputs become 0. If bit 26 = 1 both outputs keep their previous values.
- R6: An internal request state is updated on every clock. While it is low, it sets when free space is at least control[13:8]. While it is high, it stays high only while free space is at least 4*(control[22:21]+1). Both comparisons use the free space and control value before the clock edge.
- R7: dma_req equals the request state ANDed with control bit 4. Clearing bit 4 drops dma_req in the cycle the write takes effect.
- R8: The store holds 64 entries, delivered in write order. A data write while 64 entries are queued is dropped and sets the overflow flag.
- R9: Writing control with bit 0 = 1 empties the store. Free space then reads 64.
- R10: Writing status with bit 8 or bit 9 set clears the matching flag. A flag that is set again in the same cycle stays set.
- R11: dac_rate always shows control[31:29]. dac_valid is high for exactly the cycle after each strobe, and the new output pair appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| sample_strobe | input | 1 | One-cycle pulse per DAC sample period |
| dac_left | output | 24 | Left DAC word |
| dac_right | output | 24 | Right DAC word |
| dac_valid | output | 1 | Pulses when a new output pair is presented |
| dac_rate | output | 3 | Sample-rate code held for the DAC |
| dma_req | output | 1 | DMA request for more samples |

## Verification
Asymmetric sample values in the low and high bytes are written under each packing mode. This separates zero padding from top-byte repetition, and shows whether the low byte of a wide container is dropped. Stereo and mono runs use distinct values per entry, so a swapped or skipped pop is visible. Strobes into a nearly empty queue, under both underrun policies, separate silence from holding the last pair. A fill-then-drain pattern with a trigger level above the clear level checks that the request stays low inside the hysteresis band and rises only on the trigger side.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int unsigned SMP_W = 24;

    localparam logic [7:0] OFS_CTRL = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_DATA = 8'h0C;

    localparam int unsigned B_FLUSH   = 0;
    localparam int unsigned B_DREQ_EN = 4;
    localparam int unsigned B_WIDE    = 5;
    localparam int unsigned B_MONO    = 6;
    localparam int unsigned B_TRIG_LO = 8;
    localparam int unsigned B_CLR_LO  = 21;
    localparam int unsigned B_PACK    = 24;
    localparam int unsigned B_HOLD    = 26;
    localparam int unsigned B_RATE_LO = 29;
    localparam int unsigned B_UDR     = 8;
    localparam int unsigned B_OVF     = 9;

    localparam logic [31:0] CTRL_KEEP = 32'hE560_3F70;

    typedef logic [SMP_W-1:0] sample_t;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_ONE  = 2'd1,
        TAKE_TWO  = 2'd2
    } take_e;

    typedef struct packed {
        logic [2:0] rate;
        logic       hold_last;
        logic       pack_rep;
        logic [1:0] clr_code;
        logic [5:0] trig;
        logic       mono;
        logic       wide;
        logic       dreq_en;
    } tx_ctrl_t;

    function automatic tx_ctrl_t decode_ctrl(input logic [31:0] r);
        tx_ctrl_t c;
        c.rate      = r[B_RATE_LO +: 3];
        c.hold_last = r[B_HOLD];
        c.pack_rep  = r[B_PACK];
        c.clr_code  = r[B_CLR_LO +: 2];
        c.trig      = r[B_TRIG_LO +: 6];
        c.mono      = r[B_MONO];
        c.wide      = r[B_WIDE];
        c.dreq_en   = r[B_DREQ_EN];
        return c;
    endfunction

    function automatic sample_t pack_sample(input logic [31:0] w, input logic wide,
                                            input logic rep);
        if (wide) begin
            return w[31:8];
        end else if (rep) begin
            return {w[15:0], w[15:8]};
        end
        return {w[15:0], 8'h00};
    endfunction

    function automatic logic [6:0] clr_level(input logic [1:0] code);
        return {3'b000, code, 2'b00} + 7'd4;
    endfunction

endpackage

// File: rtl/atx_regs.sv
module atx_regs
    import audio_tx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [CNT_W-1:0]  free_cnt,
    input  logic              set_udr,
    input  logic              set_ovf,
    output logic [31:0]       ctrl_q,
    output logic              flush_pulse,
    output logic              data_wr,
    output logic              flag_udr,
    output logic              flag_ovf,
    output logic [31:0]       bus_rdata
);

    logic wr_ctrl;
    logic wr_stat;

    assign wr_ctrl     = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat     = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign data_wr     = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
    assign flush_pulse = wr_ctrl && bus_wdata[B_FLUSH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata & CTRL_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_udr <= 1'b0;
            flag_ovf <= 1'b0;
        end else begin
            flag_udr <= set_udr | (flag_udr & ~(wr_stat & bus_wdata[B_UDR]));
            flag_ovf <= set_ovf | (flag_ovf & ~(wr_stat & bus_wdata[B_OVF]));
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata = ctrl_q;
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[CNT_W-1:0] = free_cnt;
            bus_rdata[B_UDR]     = flag_udr;
            bus_rdata[B_OVF]     = flag_ovf;
        end
    end

endmodule

// File: rtl/atx_fifo.sv
module atx_fifo
    import audio_tx_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  sample_t          push_data,
    input  take_e            take,
    output sample_t          head0,
    output sample_t          head1,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    sample_t          mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_p1;
    logic [PTR_W-1:0] rd_p2;
    logic [PTR_W-1:0] wr_p1;
    logic             push_ok;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign rd_p1 = rd_ptr + 1'b1;
            assign rd_p2 = rd_ptr + 2'd2;
            assign wr_p1 = wr_ptr + 1'b1;
        end else begin : g_mod
            assign rd_p1 = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            assign rd_p2 = (rd_p1 == PTR_W'(DEPTH - 1)) ? '0 : rd_p1 + 1'b1;
            assign wr_p1 = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    endgenerate

    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign head0   = mem[rd_ptr];
    assign head1   = mem[rd_p1];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_p1;
            end
            case (take)
                TAKE_ONE: rd_ptr <= rd_p1;
                TAKE_TWO: rd_ptr <= rd_p2;
                default:  rd_ptr <= rd_ptr;
            endcase
            count <= count + CNT_W'(push_ok) - CNT_W'(take);
        end
    end

endmodule

// File: rtl/atx_out.sv
module atx_out
    import audio_tx_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             mono,
    input  logic             hold_last,
    input  logic [CNT_W-1:0] count,
    input  sample_t          head0,
    input  sample_t          head1,
    output take_e            take,
    output logic             underrun_evt,
    output sample_t          dac_left,
    output sample_t          dac_right,
    output logic             dac_valid
);

    logic [CNT_W-1:0] need;
    logic             enough;

    assign need   = mono ? CNT_W'(1) : CNT_W'(2);
    assign enough = (count >= need);

    always_comb begin
        take = TAKE_NONE;
        if (strobe && enough) begin
            take = mono ? TAKE_ONE : TAKE_TWO;
        end
        underrun_evt = strobe && !enough;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_left  <= '0;
            dac_right <= '0;
            dac_valid <= 1'b0;
        end else begin
            dac_valid <= strobe;
            if (strobe) begin
                if (enough) begin
                    dac_left  <= head0;
                    dac_right <= mono ? head0 : head1;
                end else if (!hold_last) begin
                    dac_left  <= '0;
                    dac_right <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/atx_dreq.sv
module atx_dreq #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [CNT_W-1:0] set_lvl,
    input  logic [CNT_W-1:0] keep_lvl,
    output logic             dma_req
);

    logic req_state;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_state <= 1'b0;
        end else if (req_state) begin
            req_state <= enable && (free_cnt >= keep_lvl);
        end else begin
            req_state <= enable && (free_cnt >= set_lvl);
        end
    end

    assign dma_req = req_state & enable;

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import audio_tx_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sample_strobe,
    output logic [23:0]       dac_left,
    output logic [23:0]       dac_right,
    output logic              dac_valid,
    output logic [2:0]        dac_rate,
    output logic              dma_req
);

    logic [31:0]      ctrl_q;
    tx_ctrl_t         cfg;
    logic             flush_pulse;
    logic             data_wr;
    logic             flag_udr;
    logic             flag_ovf;
    logic             underrun_evt;
    logic             fifo_full;
    logic [CNT_W-1:0] fifo_count;
    logic [CNT_W-1:0] free_cnt;
    sample_t          head0;
    sample_t          head1;
    sample_t          packed_in;
    take_e            take;

    assign cfg       = decode_ctrl(ctrl_q);
    assign free_cnt  = CNT_W'(DEPTH) - fifo_count;
    assign packed_in = pack_sample(bus_wdata, cfg.wide, cfg.pack_rep);
    assign dac_rate  = cfg.rate;

    atx_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .free_cnt    (free_cnt),
        .set_udr     (underrun_evt),
        .set_ovf     (data_wr && fifo_full),
        .ctrl_q      (ctrl_q),
        .flush_pulse (flush_pulse),
        .data_wr     (data_wr),
        .flag_udr    (flag_udr),
        .flag_ovf    (flag_ovf),
        .bus_rdata   (bus_rdata)
    );

    atx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_pulse),
        .push      (data_wr),
        .push_data (packed_in),
        .take      (take),
        .head0     (head0),
        .head1     (head1),
        .count     (fifo_count),
        .full      (fifo_full)
    );

    atx_out #(.CNT_W(CNT_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .strobe       (sample_strobe),
        .mono         (cfg.mono),
        .hold_last    (cfg.hold_last),
        .count        (fifo_count),
        .head0        (head0),
        .head1        (head1),
        .take         (take),
        .underrun_evt (underrun_evt),
        .dac_left     (dac_left),
        .dac_right    (dac_right),
        .dac_valid    (dac_valid)
    );

    atx_dreq #(.CNT_W(CNT_W)) u_dreq (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg.dreq_en),
        .free_cnt (free_cnt),
        .set_lvl  (CNT_W'(cfg.trig)),
        .keep_lvl (CNT_W'(clr_level(cfg.clr_code))),
        .dma_req  (dma_req)
    );

endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk
    import audio_tx_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              sample_strobe,
    input logic [23:0]       dac_left,
    input logic [23:0]       dac_right,
    input logic              dac_valid,
    input logic              dma_req,
    input logic [31:0]       ctrl_q,
    input logic [CNT_W-1:0]  fifo_count,
    input logic [CNT_W-1:0]  free_cnt,
    input logic              data_wr,
    input logic              flush_pulse,
    input logic              flag_udr,
    input logic              flag_ovf
);

    a_r7_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[B_DREQ_EN] |-> !dma_req);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH));

    a_r8_full_write_flags: assert property (@(posedge clk) disable iff (rst)
        (data_wr && fifo_count == CNT_W'(DEPTH)) |=> flag_ovf);

    a_r5_empty_strobe_flags: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && fifo_count == '0) |=> flag_udr);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |=> (fifo_count == '0));

    a_r11_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> dac_valid);

    a_r11_no_valid_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !sample_strobe |=> !dac_valid);

    a_r4_mono_sides_equal: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && ctrl_q[B_MONO] && fifo_count != '0) |=> (dac_left == dac_right));

    a_r6_rise_needs_trigger: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(free_cnt >= CNT_W'(ctrl_q[B_TRIG_LO +: 6])));

    a_r10_udr_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[B_UDR] && !sample_strobe)
        |=> !flag_udr);

endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .sample_strobe (sample_strobe),
    .dac_left      (dac_left),
    .dac_right     (dac_right),
    .dac_valid     (dac_valid),
    .dma_req       (dma_req),
    .ctrl_q        (ctrl_q),
    .fifo_count    (fifo_count),
    .free_cnt      (free_cnt),
    .data_wr       (data_wr),
    .flush_pulse   (flush_pulse),
    .flag_udr      (flag_udr),
    .flag_ovf      (flag_ovf)
);

// File: tb/audio_tx_fifo_tb_top.sv
`timescale 1ns/1ps
module audio_tx_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sample_strobe = 1'b0;
    logic [23:0] dac_left;
    logic [23:0] dac_right;
    logic        dac_valid;
    logic [2:0]  dac_rate;
    logic        dma_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    audio_tx_fifo dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .sample_strobe (sample_strobe),
        .dac_left      (dac_left),
        .dac_right     (dac_right),
        .dac_valid     (dac_valid),
        .dac_rate      (dac_rate),
        .dma_req       (dma_req)
    );

    // Behavioural reference model
    int unsigned q[$];
    logic [31:0] m_ctrl;
    bit          m_udr, m_ovf, m_st, m_v;
    int unsigned m_l, m_r;
    int          pre_size, free_sp, keep_lvl;
    bit          mono_m, stat_wr;

    function automatic int unsigned ref_pack(logic [31:0] w, logic [31:0] c);
        int unsigned s = w[15:0];
        if (c[5]) return (w >> 8) & 32'hFF_FFFF;
        if (c[24]) return (s << 8) | (s >> 8);
        return s << 8;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_ctrl = '0; m_udr = 0; m_ovf = 0; m_st = 0; m_v = 0; m_l = 0; m_r = 0;
        end else begin
            pre_size = q.size();
            free_sp  = 64 - pre_size;
            keep_lvl = 4 * (int'(m_ctrl[22:21]) + 1);
            if (m_st) m_st = m_ctrl[4] && (free_sp >= keep_lvl);
            else      m_st = m_ctrl[4] && (free_sp >= int'(m_ctrl[13:8]));
            stat_wr = bus_wr && bus_addr == 8'h08;
            if (stat_wr && bus_wdata[8]) m_udr = 0;
            if (stat_wr && bus_wdata[9]) m_ovf = 0;
            m_v = sample_strobe;
            mono_m = m_ctrl[6];
            if (sample_strobe) begin
                if (pre_size >= (mono_m ? 1 : 2)) begin
                    m_l = q.pop_front();
                    m_r = mono_m ? m_l : q.pop_front();
                end else begin
                    m_udr = 1;
                    if (!m_ctrl[26]) begin m_l = 0; m_r = 0; end
                end
            end
            if (bus_wr && bus_addr == 8'h0C) begin
                if (pre_size == 64) m_ovf = 1;
                else q.push_back(ref_pack(bus_wdata, m_ctrl));
            end
            if (bus_wr && bus_addr == 8'h04) begin
                m_ctrl = bus_wdata & 32'hE560_3F70;
                if (bus_wdata[0]) q.delete();
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    initial begin
        forever begin
            @(posedge clk);
            #1;
            check("R6/R7 dma_req", {31'b0, dma_req}, {31'b0, m_st & m_ctrl[4]});
            check("R4/R5 dac_left", {8'b0, dac_left}, m_l);
            check("R4/R5 dac_right", {8'b0, dac_right}, m_r);
            check("R11 dac_valid", {31'b0, dac_valid}, {31'b0, m_v});
            check("R11 dac_rate", {29'b0, dac_rate}, {29'b0, m_ctrl[31:29]});
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    endtask

    task automatic strobe();
        @(negedge clk);
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = 8'h00;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(1);
        rd("R1 ctrl reset", 8'h04, 32'h0);
        rd("R1 status reset", 8'h08, 32'h40);
        check("R11 rate reset", {29'b0, dac_rate}, 32'h0);

        // R2 zero padding, stereo
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'h1234);
        wr(8'h0C, 32'hABCD);
        strobe();
        check("R2 zero pad left", {8'b0, dac_left}, 32'h123400);
        check("R4 stereo right", {8'b0, dac_right}, 32'hABCD00);
        check("R11 valid pulse", {31'b0, dac_valid}, 32'h1);

        // R2 top-byte repetition
        wr(8'h04, 32'h0100_0000);
        wr(8'h0C, 32'h8001);
        wr(8'h0C, 32'h00FF);
        strobe();
        check("R2 repeat left", {8'b0, dac_left}, 32'h800180);
        check("R2 repeat right", {8'b0, dac_right}, 32'h00FF00);

        // R3 wide containers
        wr(8'h04, 32'h0100_0020);
        wr(8'h0C, 32'h89AB_CDEF);
        wr(8'h0C, 32'h1234_5678);
        strobe();
        check("R3 wide left", {8'b0, dac_left}, 32'h89ABCD);
        check("R3 wide right", {8'b0, dac_right}, 32'h123456);

        // R4 mono
        wr(8'h04, 32'h40);
        wr(8'h0C, 32'h5555);
        strobe();
        check("R4 mono left", {8'b0, dac_left}, 32'h555500);
        check("R4 mono right", {8'b0, dac_right}, 32'h555500);

        // R5 underrun with zeros
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'h1111);
        strobe();
        check("R5 zero left", {8'b0, dac_left}, 32'h0);
        rd("R5 underrun flag", 8'h08, 32'h13F);

        // R5 underrun with hold
        wr(8'h04, 32'h0400_0000);
        wr(8'h0C, 32'h2222);
        strobe();
        check("R4 order left", {8'b0, dac_left}, 32'h111100);
        check("R4 order right", {8'b0, dac_right}, 32'h222200);
        wr(8'h08, 32'h100);
        rd("R10 udr cleared", 8'h08, 32'h40);
        strobe();
        check("R5 hold left", {8'b0, dac_left}, 32'h111100);
        check("R5 hold right", {8'b0, dac_right}, 32'h222200);
        rd("R5 hold flag", 8'h08, 32'h140);
        wr(8'h08, 32'h200);
        rd("R10 other bit no effect", 8'h08, 32'h140);
        wr(8'h08, 32'h100);

        // R9 flush
        wr(8'h04, 32'h0);
        for (int i = 0; i < 3; i++) wr(8'h0C, 32'h7000 + i);
        rd("R9 before flush", 8'h08, 32'h3D);
        wr(8'h04, 32'h1);
        rd("R9 after flush", 8'h08, 32'h40);
        rd("R1 flush bit reads 0", 8'h04, 32'h0);

        // R8 overflow
        for (int i = 0; i < 66; i++) wr(8'h0C, i + 1);
        rd("R8 full and flag", 8'h08, 32'h200);
        strobe();
        check("R8 first left", {8'b0, dac_left}, 32'h000100);
        check("R8 first right", {8'b0, dac_right}, 32'h000200);
        wr(8'h08, 32'h200);
        rd("R10 ovf cleared", 8'h08, 32'h2);
        wr(8'h04, 32'h1);

        // R6 hysteresis: trigger 20, clear code 3 (keep while free >= 16)
        wr(8'h04, 32'h0060_1410);
        idle(1);
        check("R6 asserted", {31'b0, dma_req}, 32'h1);
        for (int i = 0; i < 49; i++) wr(8'h0C, 32'h100 + i);
        check("R6 held at free 16", {31'b0, dma_req}, 32'h1);
        idle(1);
        check("R6 dropped below 16", {31'b0, dma_req}, 32'h0);
        strobe(); strobe(); strobe();
        check("R6 low inside band", {31'b0, dma_req}, 32'h0);
        idle(1);
        check("R6 reasserted at 21", {31'b0, dma_req}, 32'h1);
        wr(8'h04, 32'h0060_1400);
        check("R7 forced low", {31'b0, dma_req}, 32'h0);

        // R11 rate code and R1 mask
        wr(8'h04, 32'hA000_0000);
        check("R11 rate 5", {29'b0, dac_rate}, 32'h5);
        wr(8'h04, 32'hFFFF_FFFF);
        rd("R1 control mask", 8'h04, 32'hE560_3F70);
        check("R11 rate 7", {29'b0, dac_rate}, 32'h7);
        rd("R1 other offset", 8'h10, 32'h0);
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule